// File: doc/BRIEF.md
# Boot Reset and Strap Sequencer

This block decides what a device does after each kind of reset request. A power-on or full reset captures the thirteen bootstrap pins into a held status word. A plain reset reuses the word that is already held. A local reset starts no boot at all: it only puts the cores back to idle. A plain reset also consults a power-state input, and if that input reports hibernation the sequencer resumes at the saved branch address instead of running a normal boot.

On the normal path the sequencer runs a fixed walk through its states. It latches the pins, prepares the parameters, and starts the PLL and waits for lock unless the boot device forces bypass. It then publishes a dispatch code together with the entry address of the matching boot handler. After that it releases the single boot-master core. Every other core stays idle until it receives a wake interrupt, and it then starts at the address it finds in its own magic location.

Top module: `boot_reset_sequencer`

## Requirements
- R1: While the block reset `rstN` is low, and until the first boot, `devStatus`, `pllEnable`, `pllMultSel`, `bootMode`, `branchAddr`, `branchValid`, `resumeTaken`, `coreRun` and `coreStartAddr` read zero.
- R2: A power-on or full reset copies `strapPins` into `devStatus`. In that word, bits [2:0] hold the boot device code, bits [9:3] hold the device configuration and bits [12:10] hold the PLL select.
- R3: A plain reset leaves `devStatus` unchanged even when the strap pins have changed. It still runs a boot with the held word.
- R4: A local reset clears every `coreRun` bit. It leaves `devStatus`, `pllEnable`, `branchAddr` and `branchValid` unchanged and starts no boot sequence.
- R5: A plain reset taken while `pwrHibFlag` is 1 ends with `branchAddr` equal to `pwrBranchAddr` and `resumeTaken` equal to 1. Power-on and full resets ignore the flag and end with `resumeTaken` equal to 0.
- R6: For device code 5 or 6, `pllEnable` and `pllMultSel` stay 0, because bits [12:10] then count as extended configuration. For every other code, `pllEnable` is 1 and `pllMultSel` equals `devStatus[12:10]`.
- R7: While the PLL is being started, the sequence waits for `pllLock`. The master core is not released before `pllLock` reads 1.
- R8: A normal boot ends with `bootMode` equal to the device code and `branchAddr` equal to 0x2000_0000 + code × 0x100. `branchValid` is then 1.
- R9: At the end of a boot, only core 0, the master, is released. Its `coreStartAddr` slice equals `branchAddr`.
- R10: A non-running core whose `wakeIrq` bit is set after a boot has completed starts running at its `magicAddr` slice. A wake request that arrives while a boot is still in progress is ignored.
- R11: When several reset requests arrive in the same cycle, the strongest one is acted on. The order from strongest to weakest is power-on, full, plain, local.
- R12: Any reset that starts a boot clears `coreRun`, `branchValid`, `resumeTaken` and `pllEnable` in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| porReq | input | 1 | Power-on reset request pulse |
| fullReq | input | 1 | Full reset request pulse |
| plainReq | input | 1 | Plain reset request pulse |
| localReq | input | 1 | Local (core-only) reset request pulse |
| strapPins | input | 13 | Bootstrap pin levels |
| pwrHibFlag | input | 1 | Power-state hibernation indication |
| pwrBranchAddr | input | 32 | Saved resume address |
| pllLock | input | 1 | PLL lock indication |
| wakeIrq | input | 4 | Per-core wake interrupt |
| magicAddr | input | 128 | Per-core magic-location start addresses, core i in bits [32i+31:32i] |
| devStatus | output | 13 | Latched strap word |
| pllEnable | output | 1 | PLL in use (0 = bypass) |
| pllMultSel | output | 3 | PLL multiplier select |
| bootMode | output | 3 | Boot dispatch code |
| branchAddr | output | 32 | Entry address chosen by the sequence |
| branchValid | output | 1 | Branch address is valid |
| resumeTaken | output | 1 | Last sequence was a hibernation resume |
| coreRun | output | 4 | Per-core running flags |
| coreStartAddr | output | 128 | Per-core start address, core i in bits [32i+31:32i] |

## Verification
The hardest situation to reach is a wake interrupt that lands in the middle of a boot. A boot normally finishes within a few cycles, so such an interrupt has almost no window to arrive. The bench holds `pllLock` low so that the sequence stays parked in the PLL wait. It then pulses a core's wake line and confirms that the core stays idle. The same stall is used to show that the PLL enable and select are already visible while the master is still held back.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

  typedef enum logic [6:0] {
    ST_IDLE   = 7'b0000001,
    ST_LATCH  = 7'b0000010,
    ST_PINIT  = 7'b0000100,
    ST_PLL    = 7'b0001000,
    ST_DISP   = 7'b0010000,
    ST_RESUME = 7'b0100000,
    ST_DONE   = 7'b1000000
  } seqState_t;

  typedef struct packed {
    logic bootStart;
    logic latch;
    logic pllStart;
    logic dispatch;
    logic resume;
    logic relMaster;
    logic localClr;
  } seqStrobe_t;

endpackage

// File: rtl/bootseq_ctrl.sv
module bootseq_ctrl
  import bootseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       porReq,
  input  logic       fullReq,
  input  logic       plainReq,
  input  logic       localReq,
  input  logic       hibFlag,
  input  logic       needPll,
  input  logic       pllLock,
  output seqStrobe_t strobe
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE:   nextState = ST_IDLE;
      ST_LATCH:  begin strobe.latch = 1'b1; nextState = ST_PINIT; end
      ST_PINIT:  begin
        if (needPll) begin
          strobe.pllStart = 1'b1;
          nextState = ST_PLL;
        end else begin
          nextState = ST_DISP;
        end
      end
      ST_PLL:    if (pllLock) nextState = ST_DISP;
      ST_DISP:   begin strobe.dispatch = 1'b1; nextState = ST_DONE; end
      ST_RESUME: begin strobe.resume = 1'b1; nextState = ST_DONE; end
      ST_DONE:   begin strobe.relMaster = 1'b1; nextState = ST_IDLE; end
      default:   nextState = ST_IDLE;
    endcase

    // strongest request wins: power-on, full, plain, local
    if (porReq || fullReq) begin
      strobe           = '0;
      strobe.bootStart = 1'b1;
      nextState        = ST_LATCH;
    end else if (plainReq) begin
      strobe           = '0;
      strobe.bootStart = 1'b1;
      nextState        = hibFlag ? ST_RESUME : ST_PINIT;
    end else if (localReq) begin
      strobe.localClr  = 1'b1;
    end
  end

  // R7
  pll_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PLL && !pllLock && !porReq && !fullReq && !plainReq) |=> state == ST_PLL);

  // R4
  local_noboot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && localReq && !porReq && !fullReq && !plainReq) |=> state == ST_IDLE);

endmodule

// File: rtl/bootseq_dp.sv
module bootseq_dp
  import bootseq_pkg::*;
#(
  parameter int DEV_W = 3,
  parameter int CFG_W = 7,
  parameter int PLL_W = 3,
  parameter int AW = 32,
  parameter int NCORES = 4,
  parameter int MASTER = 0,
  parameter int BYPASS_CODE_A = 5,
  parameter int BYPASS_CODE_B = 6,
  parameter logic [AW-1:0] HANDLER_BASE = 32'h2000_0000,
  parameter int HANDLER_STRIDE = 256,
  localparam int STRAP_W = DEV_W + CFG_W + PLL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [STRAP_W-1:0]   strapPins,
  input  logic [AW-1:0]        pwrBranchAddr,
  input  logic [NCORES-1:0]    wakeIrq,
  input  logic [NCORES*AW-1:0] magicAddr,
  output logic                 needPll,
  output logic [STRAP_W-1:0]   devStatus,
  output logic                 pllEnable,
  output logic [PLL_W-1:0]     pllMultSel,
  output logic [DEV_W-1:0]     bootMode,
  output logic [AW-1:0]        branchAddr,
  output logic                 branchValid,
  output logic                 resumeTaken,
  output logic [NCORES-1:0]    coreRun,
  output logic [NCORES*AW-1:0] coreStartAddr
);

  localparam logic [AW-1:0]    STRIDE_V = AW'(HANDLER_STRIDE);
  localparam logic [DEV_W-1:0] CODE_A   = DEV_W'(BYPASS_CODE_A);
  localparam logic [DEV_W-1:0] CODE_B   = DEV_W'(BYPASS_CODE_B);

  logic [DEV_W-1:0] devField;
  logic [PLL_W-1:0] pllField;
  logic [AW-1:0]    handlerAddr;
  logic             bootDone;

  assign devField    = devStatus[DEV_W-1:0];
  assign pllField    = devStatus[STRAP_W-1 -: PLL_W];
  assign needPll     = !(devField == CODE_A || devField == CODE_B);
  assign handlerAddr = HANDLER_BASE + (AW'(devField) * STRIDE_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devStatus   <= '0;
      pllEnable   <= 1'b0;
      pllMultSel  <= '0;
      bootMode    <= '0;
      branchAddr  <= '0;
      branchValid <= 1'b0;
      resumeTaken <= 1'b0;
      bootDone    <= 1'b0;
    end else begin
      if (strobe.latch) devStatus <= strapPins;
      if (strobe.bootStart) begin
        pllEnable   <= 1'b0;
        pllMultSel  <= '0;
        branchValid <= 1'b0;
        resumeTaken <= 1'b0;
        bootDone    <= 1'b0;
      end
      if (strobe.pllStart) begin
        pllEnable  <= 1'b1;
        pllMultSel <= pllField;
      end
      if (strobe.dispatch) begin
        bootMode    <= devField;
        branchAddr  <= handlerAddr;
        branchValid <= 1'b1;
      end
      if (strobe.resume) begin
        branchAddr  <= pwrBranchAddr;
        branchValid <= 1'b1;
        resumeTaken <= 1'b1;
      end
      if (strobe.relMaster) bootDone <= 1'b1;
    end
  end

  logic          runQ   [NCORES];
  logic [AW-1:0] startQ [NCORES];

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    if (i == MASTER) begin : g_master
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          runQ[i]   <= 1'b0;
          startQ[i] <= '0;
        end else if (strobe.bootStart || strobe.localClr) begin
          runQ[i] <= 1'b0;
        end else if (strobe.relMaster) begin
          runQ[i]   <= 1'b1;
          startQ[i] <= branchAddr;
        end else if (bootDone && wakeIrq[i] && !runQ[i]) begin
          runQ[i]   <= 1'b1;
          startQ[i] <= magicAddr[i*AW +: AW];
        end
      end
    end else begin : g_slave
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          runQ[i]   <= 1'b0;
          startQ[i] <= '0;
        end else if (strobe.bootStart || strobe.localClr) begin
          runQ[i] <= 1'b0;
        end else if (bootDone && wakeIrq[i] && !runQ[i]) begin
          runQ[i]   <= 1'b1;
          startQ[i] <= magicAddr[i*AW +: AW];
        end
      end

      // R10
      wake_src_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(runQ[i]) |-> $past(wakeIrq[i]));
    end
    assign coreRun[i] = runQ[i];
    assign coreStartAddr[i*AW +: AW] = startQ[i];
  end

  // R6
  pll_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    pllEnable |-> needPll);

  // R5
  resume_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resumeTaken) |-> (branchValid && branchAddr == $past(pwrBranchAddr)));

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devStatus) |-> $past(strobe.latch));

endmodule

// File: rtl/boot_reset_sequencer.sv
module boot_reset_sequencer
  import bootseq_pkg::*;
#(
  parameter int DEV_W = 3,
  parameter int CFG_W = 7,
  parameter int PLL_W = 3,
  parameter int AW = 32,
  parameter int NCORES = 4,
  parameter int MASTER = 0,
  parameter int BYPASS_CODE_A = 5,
  parameter int BYPASS_CODE_B = 6,
  parameter logic [AW-1:0] HANDLER_BASE = 32'h2000_0000,
  parameter int HANDLER_STRIDE = 256,
  localparam int STRAP_W = DEV_W + CFG_W + PLL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 porReq,
  input  logic                 fullReq,
  input  logic                 plainReq,
  input  logic                 localReq,
  input  logic [STRAP_W-1:0]   strapPins,
  input  logic                 pwrHibFlag,
  input  logic [AW-1:0]        pwrBranchAddr,
  input  logic                 pllLock,
  input  logic [NCORES-1:0]    wakeIrq,
  input  logic [NCORES*AW-1:0] magicAddr,
  output logic [STRAP_W-1:0]   devStatus,
  output logic                 pllEnable,
  output logic [PLL_W-1:0]     pllMultSel,
  output logic [DEV_W-1:0]     bootMode,
  output logic [AW-1:0]        branchAddr,
  output logic                 branchValid,
  output logic                 resumeTaken,
  output logic [NCORES-1:0]    coreRun,
  output logic [NCORES*AW-1:0] coreStartAddr
);

  seqStrobe_t strobe;
  logic       needPll;

  bootseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .porReq   (porReq),
    .fullReq  (fullReq),
    .plainReq (plainReq),
    .localReq (localReq),
    .hibFlag  (pwrHibFlag),
    .needPll  (needPll),
    .pllLock  (pllLock),
    .strobe   (strobe)
  );

  bootseq_dp #(
    .DEV_W(DEV_W), .CFG_W(CFG_W), .PLL_W(PLL_W), .AW(AW), .NCORES(NCORES),
    .MASTER(MASTER), .BYPASS_CODE_A(BYPASS_CODE_A), .BYPASS_CODE_B(BYPASS_CODE_B),
    .HANDLER_BASE(HANDLER_BASE), .HANDLER_STRIDE(HANDLER_STRIDE)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .strapPins     (strapPins),
    .pwrBranchAddr (pwrBranchAddr),
    .wakeIrq       (wakeIrq),
    .magicAddr     (magicAddr),
    .needPll       (needPll),
    .devStatus     (devStatus),
    .pllEnable     (pllEnable),
    .pllMultSel    (pllMultSel),
    .bootMode      (bootMode),
    .branchAddr    (branchAddr),
    .branchValid   (branchValid),
    .resumeTaken   (resumeTaken),
    .coreRun       (coreRun),
    .coreStartAddr (coreStartAddr)
  );

endmodule

// File: tb/boot_reset_sequencer_bench.sv
module boot_reset_sequencer_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         porReq = 0, fullReq = 0, plainReq = 0, localReq = 0;
  logic [12:0]  strapPins = '0;
  logic         pwrHibFlag = 0;
  logic [31:0]  pwrBranchAddr = '0;
  logic         pllLock = 1'b1;
  logic [3:0]   wakeIrq = '0;
  logic [127:0] magicAddr = '0;
  logic [12:0]  devStatus;
  logic         pllEnable;
  logic [2:0]   pllMultSel;
  logic [2:0]   bootMode;
  logic [31:0]  branchAddr;
  logic         branchValid;
  logic         resumeTaken;
  logic [3:0]   coreRun;
  logic [127:0] coreStartAddr;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  boot_reset_sequencer u_boot_reset_sequencer (
    .clk(clk), .rstN(rstN), .porReq(porReq), .fullReq(fullReq), .plainReq(plainReq),
    .localReq(localReq), .strapPins(strapPins), .pwrHibFlag(pwrHibFlag),
    .pwrBranchAddr(pwrBranchAddr), .pllLock(pllLock), .wakeIrq(wakeIrq),
    .magicAddr(magicAddr), .devStatus(devStatus), .pllEnable(pllEnable),
    .pllMultSel(pllMultSel), .bootMode(bootMode), .branchAddr(branchAddr),
    .branchValid(branchValid), .resumeTaken(resumeTaken), .coreRun(coreRun),
    .coreStartAddr(coreStartAddr)
  );

  function automatic bit expPll(input logic [12:0] s);
    return !(s[2:0] == 3'd5 || s[2:0] == 3'd6);
  endfunction

  function automatic logic [31:0] expAddr(input logic [12:0] s);
    return 32'h2000_0000 + 32'(s[2:0]) * 32'h100;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit p, input bit f, input bit pl, input bit l);
    @(negedge clk);
    porReq = p; fullReq = f; plainReq = pl; localReq = l;
    @(negedge clk);
    porReq = 0; fullReq = 0; plainReq = 0; localReq = 0;
  endtask

  task automatic waitMaster(input string req);
    bit seen;
    seen = 0;
    for (int k = 0; k < 30 && !seen; k++) begin
      if (coreRun[0]) seen = 1;
      else @(negedge clk);
    end
    chk(seen, req, 32'(coreRun), 32'h1);
  endtask

  task automatic checkNormal(input logic [12:0] s, input string req);
    chk(devStatus == s, req, 32'(devStatus), 32'(s));
    chk(pllEnable == expPll(s), req, 32'(pllEnable), 32'(expPll(s)));
    chk(pllMultSel == (expPll(s) ? s[12:10] : 3'd0), req, 32'(pllMultSel),
        32'(expPll(s) ? s[12:10] : 3'd0));
    chk(bootMode == s[2:0], req, 32'(bootMode), 32'(s[2:0]));
    chk(branchAddr == expAddr(s) && branchValid, req, branchAddr, expAddr(s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [12:0] s;
    logic [31:0] keepAddr;
    logic [12:0] keepStat;
    logic [3:0]  runSnap;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(devStatus == 0 && pllEnable == 0 && pllMultSel == 0 && branchValid == 0,
        "R1", 32'(devStatus), 32'h0);
    chk(coreRun == 0 && coreStartAddr == 0 && branchAddr == 0 && resumeTaken == 0,
        "R1", 32'(coreRun), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(devStatus == 0 && coreRun == 0 && bootMode == 0, "R1", 32'(devStatus), 32'h0);

    // R2 R6 R8 R9: power-on, I2C code with PLL bits set (bypass)
    strapPins = {3'b101, 7'h2A, 3'd5};
    magicAddr = {32'h8000_3333, 32'h8000_2222, 32'h8000_1111, 32'h8000_0000};
    pulse(1, 0, 0, 0);
    waitMaster("R9");
    checkNormal(strapPins, "R2_R6_R8");
    chk(coreRun == 4'b0001, "R9", 32'(coreRun), 32'h1);
    chk(coreStartAddr[31:0] == branchAddr, "R9", coreStartAddr[31:0], branchAddr);

    // R7 R12 R10: full reset with PLL wait, wake ignored mid-boot
    pllLock = 1'b0;
    strapPins = {3'b011, 7'h11, 3'd1};
    pulse(0, 1, 0, 0);
    chk(coreRun == 0 && branchValid == 0, "R12", 32'(coreRun), 32'h0);
    repeat (8) @(negedge clk);
    wakeIrq = 4'b1000;
    @(negedge clk);
    wakeIrq = '0;
    repeat (3) @(negedge clk);
    chk(coreRun == 0, "R7_R10", 32'(coreRun), 32'h0);
    chk(pllEnable == 1 && pllMultSel == 3'b011, "R6", 32'(pllMultSel), 32'h3);
    pllLock = 1'b1;
    waitMaster("R7");
    checkNormal(strapPins, "R7_R8");

    // R10 wake a slave after boot
    @(negedge clk);
    wakeIrq = 4'b0100;
    @(negedge clk);
    wakeIrq = '0;
    @(negedge clk);
    chk(coreRun == 4'b0101, "R10", 32'(coreRun), 32'h5);
    chk(coreStartAddr[95:64] == 32'h8000_2222, "R10", coreStartAddr[95:64], 32'h8000_2222);

    // R3 plain reset keeps the held status
    s = strapPins;
    strapPins = {3'b110, 7'h7F, 3'd7};
    pulse(0, 0, 1, 0);
    waitMaster("R3");
    checkNormal(s, "R3");

    // R4 local reset
    keepAddr = branchAddr;
    keepStat = devStatus;
    pulse(0, 0, 0, 1);
    repeat (6) @(negedge clk);
    chk(coreRun == 0, "R4", 32'(coreRun), 32'h0);
    chk(devStatus == keepStat && branchAddr == keepAddr && branchValid && pllEnable,
        "R4", branchAddr, keepAddr);

    // R5 hibernation resume on plain reset
    pwrHibFlag = 1'b1;
    pwrBranchAddr = 32'h1234_5678;
    pulse(0, 0, 1, 0);
    waitMaster("R5");
    chk(branchAddr == 32'h1234_5678 && resumeTaken, "R5", branchAddr, 32'h1234_5678);
    chk(pllEnable == 0 && coreStartAddr[31:0] == 32'h1234_5678, "R5_R12",
        coreStartAddr[31:0], 32'h1234_5678);

    // R5 power-on ignores the flag
    strapPins = {3'b010, 7'h05, 3'd4};
    pulse(1, 0, 0, 0);
    waitMaster("R5");
    chk(resumeTaken == 0, "R5", 32'(resumeTaken), 32'h0);
    checkNormal(strapPins, "R5");

    // R11 priority: power-on beats plain with hibernation pending
    strapPins = {3'b001, 7'h33, 3'd2};
    pulse(1, 0, 1, 0);
    waitMaster("R11");
    chk(resumeTaken == 0, "R11", 32'(resumeTaken), 32'h0);
    checkNormal(strapPins, "R11");
    // plain beats local: a boot still runs
    pwrHibFlag = 1'b0;
    pulse(0, 0, 1, 1);
    chk(branchValid == 0, "R11", 32'(branchValid), 32'h0);
    waitMaster("R11");
    // full beats plain: straps re-latched
    strapPins = {3'b111, 7'h01, 3'd3};
    pulse(0, 1, 1, 0);
    waitMaster("R11");
    checkNormal(strapPins, "R11");

    // randomised power-on / full boots
    void'($urandom(32'd7341));
    for (int n = 0; n < 40; n++) begin
      s = 13'($urandom);
      strapPins = s;
      runSnap = 4'($urandom);
      if (runSnap[0]) pulse(1, 0, 0, 0);
      else pulse(0, 1, 0, 0);
      waitMaster("R2");
      checkNormal(s, "R2_R6_R8_rand");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule